// File: doc/BRIEF.md
# CAM Lookup Pipeline with Subbank Wake Control

This block is the sequencing core of a tag lookup engine. A small content-addressable tag store is paired with a data RAM. The engine accepts one command per clock. A command is a READ (find the tag, return its data), an OVERWRITE (find the tag, replace its data) or a WRITE (store a new tag together with its data). Each command moves through four stages. Stage 1 derives a subbank identifier from the tag. Stage 2 is an address-decode step for WRITE and an idle step for searches. Stage 3 is the only stage that touches the tag store, and stage 4 is the only stage that touches the data RAM. The block never stalls.

The tag store is split into banks and subbanks. The bank comes from the low bits of the tag's population count, and the subbank within that bank comes from the low tag bits. The block drives one wake bit per subbank. A subbank's bit is raised in the cycle before its tag-store access, using the stage-2 slot, and stays raised during that access. All other subbanks are held in the low-power state. The result of each command appears on a registered output port four cycles after the command is accepted.

Top module: `lookup_pipe`

## Requirements
- R1: The subbank identifier of a tag is {popcount(tag) mod NBANK, tag mod NSUB}, with the bank part in the upper bits. Bit `id` of `wake_o` belongs to that subbank.
- R2: A command accepted on a clock edge with `cmd_valid` high produces exactly one result, with `res_valid` high, four edges later. A new command may be accepted on every edge, and `res_valid` is low four edges after an edge with no command.
- R3: A READ whose tag is present returns `res_hit`=1 and, in `res_data`, the data last written to that entry.
- R4: An OVERWRITE whose tag is present returns `res_hit`=1 and replaces the entry's data, which later READs return.
- R5: A READ or OVERWRITE whose tag is absent returns `res_hit`=0 and `res_data`=0, and leaves the RAM unchanged.
- R6: A WRITE (op code 2'b10 or 2'b11) takes the lowest-numbered free slot of its subbank. When the subbank is full, it replaces slot 0. A WRITE always reports `res_hit`=1 and `res_data`=0. A search that matches several slots uses the lowest-numbered one.
- R7: Commands are processed as if run one after another. A READ or OVERWRITE issued on the cycle right after a WRITE of the same tag sees that WRITE, and back-to-back WRITEs to one subbank take distinct slots.
- R8: A command's subbank wake bit is high in the two cycles during which the command is in stages 2 and 3. Every other bit is low, so at most two bits are high, and all bits are low when no command was accepted on the two previous edges.
- R9: The tag store is searched or written only in a subbank whose wake bit was high in the preceding cycle.
- R10: After reset, all entries are invalid, and `res_valid`, `res_hit`, `res_data` and `wake_o` are zero.
- Op codes: READ = 2'b00 and OVERWRITE = 2'b01. `res_op` echoes the command's op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 2 | 00 READ, 01 OVERWRITE, 1x WRITE |
| cmd_tag | input | TAG_W | Lookup or store tag |
| cmd_data | input | DATA_W | RAM data for OVERWRITE and WRITE |
| res_valid | output | 1 | Result of the command accepted four edges earlier |
| res_op | output | 2 | Op code of that command |
| res_hit | output | 1 | Tag found (always 1 for WRITE) |
| res_data | output | DATA_W | Data read by a hitting READ, else zero |
| wake_o | output | NBANK*NSUB | Per-subbank full-power request |

## Verification
On every cycle, the bound checker confirms these properties:
- A tag-store access only lands in a subbank that was awake the cycle before.
- No more than two subbanks are awake at once, and all subbanks sleep after two idle input cycles.
- Results keep the fixed four-edge latency.
- A miss never carries data, and a WRITE always reports a hit.

The returned data, the choice of allocated slot, the replacement of slot 0 in a full subbank, and the visibility of a WRITE to the command right behind it can only be shown by the bench. The bench drives directed sequences and seeded random traffic and compares the results against a sequential reference model.

// File: rtl/lookup_pipe_pkg.sv
package lookup_pipe_pkg;

   typedef enum logic [1:0] {
      OP_READ      = 2'b00,
      OP_OVWR      = 2'b01,
      OP_WRITE     = 2'b10,
      OP_WRITE_ALT = 2'b11
   } op_e;

   function automatic logic op_is_write(op_e o);
      return (o == OP_WRITE) || (o == OP_WRITE_ALT);
   endfunction

endpackage

// File: rtl/lookup_param_ext.sv
module lookup_param_ext #(
   parameter int TAG_W  = 8,
   parameter int BANK_W = 2,
   parameter int SUB_W  = 2
) (
   input  logic [TAG_W-1:0]        tag,
   output logic [BANK_W+SUB_W-1:0] id
);
   localparam int CNT_W = $clog2(TAG_W + 1);

   if (BANK_W > CNT_W) begin : g_bad_bank
      $error("lookup_param_ext: more bank bits than popcount bits");
   end

   logic [CNT_W-1:0] ones;

   always_comb begin
      ones = '0;
      for (int i = 0; i < TAG_W; i++) begin
         ones = ones + CNT_W'(tag[i]);
      end
      id = {ones[BANK_W-1:0], tag[SUB_W-1:0]};
   end
endmodule

// File: rtl/lookup_tag_store.sv
module lookup_tag_store #(
   parameter int TAG_W  = 8,
   parameter int NSUBT  = 16,
   parameter int DEPTH  = 4,
   parameter int ID_W   = 4,
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   alloc_id,
   input  logic              excl_vld,
   input  logic [ID_W-1:0]   excl_id,
   input  logic [SLOT_W-1:0] excl_slot,
   output logic [SLOT_W-1:0] alloc_slot,
   input  logic [ID_W-1:0]   srch_id,
   input  logic [TAG_W-1:0]  srch_tag,
   output logic              srch_hit,
   output logic [SLOT_W-1:0] srch_slot,
   input  logic              wr_en,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [TAG_W-1:0]  wr_tag
);
   logic [DEPTH-1:0] vld  [NSUBT];
   logic [TAG_W-1:0] tags [NSUBT][DEPTH];
   logic [DEPTH-1:0] free;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < NSUBT; g++) vld[g] <= '0;
      end else if (wr_en) begin
         vld[wr_id][wr_slot] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tags[wr_id][wr_slot] <= wr_tag;
   end

   // Slot choice for a WRITE in decode; the slot claimed by the WRITE one
   // stage ahead is not yet marked valid, so it is masked here.
   always_comb begin
      free = ~vld[alloc_id];
      if (excl_vld && (excl_id == alloc_id)) free[excl_slot] = 1'b0;
      alloc_slot = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (free[i]) alloc_slot = SLOT_W'(i);
      end
   end

   // Parallel compare inside one subbank, lowest slot wins.
   always_comb begin
      srch_hit  = 1'b0;
      srch_slot = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (vld[srch_id][i] && (tags[srch_id][i] == srch_tag)) begin
            srch_hit  = 1'b1;
            srch_slot = SLOT_W'(i);
         end
      end
   end
endmodule

// File: rtl/lookup_data_ram.sv
module lookup_data_ram #(
   parameter int DATA_W = 8,
   parameter int WORDS  = 64,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/lookup_wake_ctl.sv
module lookup_wake_ctl #(
   parameter int NSUBT = 16,
   parameter int ID_W  = 4
) (
   input  logic             a_vld,
   input  logic [ID_W-1:0]  a_id,
   input  logic             b_vld,
   input  logic [ID_W-1:0]  b_id,
   output logic [NSUBT-1:0] wake
);
   for (genvar g = 0; g < NSUBT; g++) begin : g_sub
      assign wake[g] = (a_vld && (a_id == ID_W'(g))) || (b_vld && (b_id == ID_W'(g)));
   end
endmodule

// File: rtl/lookup_pipe.sv
module lookup_pipe
   import lookup_pipe_pkg::*;
#(
   parameter int TAG_W  = 8,
   parameter int DATA_W = 8,
   parameter int NBANK  = 4,
   parameter int NSUB   = 4,
   parameter int DEPTH  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [1:0]             cmd_op,
   input  logic [TAG_W-1:0]       cmd_tag,
   input  logic [DATA_W-1:0]      cmd_data,
   output logic                   res_valid,
   output logic [1:0]             res_op,
   output logic                   res_hit,
   output logic [DATA_W-1:0]      res_data,
   output logic [NBANK*NSUB-1:0]  wake_o
);
   localparam int BANK_W = $clog2(NBANK);
   localparam int SUB_W  = $clog2(NSUB);
   localparam int ID_W   = BANK_W + SUB_W;
   localparam int NSUBT  = NBANK * NSUB;
   localparam int SLOT_W = $clog2(DEPTH);
   localparam int ADDR_W = ID_W + SLOT_W;

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("lookup_pipe: NBANK must be a power of two >= 2");
   end
   if (NSUB < 2 || (NSUB & (NSUB - 1)) != 0) begin : g_bad_nsub
      $error("lookup_pipe: NSUB must be a power of two >= 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lookup_pipe: DEPTH must be a power of two >= 2");
   end
   if (SUB_W > TAG_W) begin : g_bad_tag
      $error("lookup_pipe: TAG_W too narrow for subbank select");
   end

   // stage 1: parameter extraction
   logic [ID_W-1:0] ext_id;

   lookup_param_ext #(.TAG_W(TAG_W), .BANK_W(BANK_W), .SUB_W(SUB_W)) u_ext (
      .tag (cmd_tag),
      .id  (ext_id)
   );

   // stage registers
   logic              s2_vld, s3_vld, s4_vld;
   op_e               s2_op, s3_op, s4_op;
   logic [TAG_W-1:0]  s2_tag, s3_tag;
   logic [DATA_W-1:0] s2_data, s3_data, s4_data;
   logic [ID_W-1:0]   s2_id, s3_id;
   logic [SLOT_W-1:0] s3_slot;
   logic              s4_hit;
   logic [ADDR_W-1:0] s4_addr;

   logic [SLOT_W-1:0] alloc_slot, srch_slot, s3_pick;
   logic              srch_hit, s3_is_wr, s3_hit_n;
   logic [DATA_W-1:0] ram_rd;
   logic              ram_we;

   assign s3_is_wr = op_is_write(s3_op);
   assign s3_hit_n = s3_is_wr | srch_hit;
   assign s3_pick  = s3_is_wr ? s3_slot : srch_slot;

   lookup_tag_store #(
      .TAG_W(TAG_W), .NSUBT(NSUBT), .DEPTH(DEPTH), .ID_W(ID_W), .SLOT_W(SLOT_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_id   (s2_id),
      .excl_vld   (s3_vld && s3_is_wr),
      .excl_id    (s3_id),
      .excl_slot  (s3_slot),
      .alloc_slot (alloc_slot),
      .srch_id    (s3_id),
      .srch_tag   (s3_tag),
      .srch_hit   (srch_hit),
      .srch_slot  (srch_slot),
      .wr_en      (s3_vld && s3_is_wr),
      .wr_id      (s3_id),
      .wr_slot    (s3_slot),
      .wr_tag     (s3_tag)
   );

   assign ram_we = s4_vld && s4_hit && (s4_op != OP_READ);

   lookup_data_ram #(.DATA_W(DATA_W), .WORDS(NSUBT * DEPTH), .ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (s4_addr),
      .wdata (s4_data),
      .rdata (ram_rd)
   );

   // stage 2 (idle / decode) and stage 3 (tag-store access) wake their subbank
   lookup_wake_ctl #(.NSUBT(NSUBT), .ID_W(ID_W)) u_wake (
      .a_vld (s2_vld),
      .a_id  (s2_id),
      .b_vld (s3_vld),
      .b_id  (s3_id),
      .wake  (wake_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_vld <= 1'b0;  s2_op <= OP_READ; s2_tag <= '0; s2_data <= '0; s2_id <= '0;
         s3_vld <= 1'b0;  s3_op <= OP_READ; s3_tag <= '0; s3_data <= '0; s3_id <= '0;
         s3_slot <= '0;
         s4_vld <= 1'b0;  s4_op <= OP_READ; s4_hit <= 1'b0; s4_addr <= '0; s4_data <= '0;
         res_valid <= 1'b0; res_op <= 2'b00; res_hit <= 1'b0; res_data <= '0;
      end else begin
         s2_vld  <= cmd_valid;
         s2_op   <= op_e'(cmd_op);
         s2_tag  <= cmd_tag;
         s2_data <= cmd_data;
         s2_id   <= ext_id;

         s3_vld  <= s2_vld;
         s3_op   <= s2_op;
         s3_tag  <= s2_tag;
         s3_data <= s2_data;
         s3_id   <= s2_id;
         s3_slot <= alloc_slot;

         s4_vld  <= s3_vld;
         s4_op   <= s3_op;
         s4_hit  <= s3_vld && s3_hit_n;
         s4_addr <= {s3_id, s3_pick};
         s4_data <= s3_data;

         res_valid <= s4_vld;
         res_op    <= s4_op;
         res_hit   <= s4_vld && s4_hit;
         res_data  <= (s4_vld && s4_hit && (s4_op == OP_READ)) ? ram_rd : '0;
      end
   end
endmodule

// File: rtl/lookup_pipe_chk.sv
module lookup_pipe_chk #(
   parameter int NSUBT  = 16,
   parameter int ID_W   = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              s3_vld,
   input logic [ID_W-1:0]   s3_id,
   input logic [NSUBT-1:0]  wake_o,
   input logic              res_valid,
   input logic [1:0]        res_op,
   input logic              res_hit,
   input logic [DATA_W-1:0] res_data
);
   logic [NSUBT-1:0] wake_q;

   always_ff @(posedge clk) begin
      if (!rst_n) wake_q <= '0;
      else        wake_q <= wake_o;
   end

   // R9: tag-store access only where the wake bit was up a cycle earlier
   assert_awake_before_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      s3_vld |-> wake_q[s3_id]);

   // R8: no more than two subbanks at full power
   assert_wake_at_most_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wake_o) <= 2);

   // R8: everything sleeps after two idle input cycles
   assert_idle_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cmd_valid) && !$past(cmd_valid, 2)) |-> (wake_o == '0));

   // R2: fixed four-edge latency, one result per command
   assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == $past(cmd_valid, 4));

   // R5: a miss carries no data
   assert_miss_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_data == '0));

   // R6: a WRITE always reports a hit
   assert_write_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_op[1]) |-> res_hit);
endmodule

bind lookup_pipe lookup_pipe_chk #(.NSUBT(NSUBT), .ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .s3_vld    (s3_vld),
   .s3_id     (s3_id),
   .wake_o    (wake_o),
   .res_valid (res_valid),
   .res_op    (res_op),
   .res_hit   (res_hit),
   .res_data  (res_data)
);

// File: tb/lookup_pipe_bench.sv
module lookup_pipe_bench;
   localparam int TW = 8;
   localparam int DW = 8;
   localparam int NS = 16;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [TW-1:0] cmd_tag = '0;
   logic [DW-1:0] cmd_data = '0;
   logic          res_valid;
   logic [1:0]    res_op;
   logic          res_hit;
   logic [DW-1:0] res_data;
   logic [NS-1:0] wake_o;

   int n_chk = 0;
   int n_bad = 0;
   int k = 0;

   // reference model state
   logic [TW-1:0] m_tag [NS][DP];
   bit            m_vld [NS][DP];
   logic [DW-1:0] m_ram [NS*DP];

   // expected results, ring indexed by step
   bit            e_vld  [8];
   logic [1:0]    e_op   [8];
   logic          e_hit  [8];
   logic [DW-1:0] e_data [8];
   int            e_id   [8];

   always #4 clk = ~clk;

   lookup_pipe u_lookup_pipe (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_tag(cmd_tag), .cmd_data(cmd_data), .res_valid(res_valid),
      .res_op(res_op), .res_hit(res_hit), .res_data(res_data), .wake_o(wake_o)
   );

   function automatic int sub_id(input logic [TW-1:0] t);
      int c = 0;
      for (int i = 0; i < TW; i++) c += int'(t[i]);
      return ((c % 4) * 4) + int'(t[1:0]);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (step %0d)", req, act, exp, k);
      end
   endtask

   task automatic model(input logic [1:0] op, input logic [TW-1:0] t, input logic [DW-1:0] d,
                        output logic hit, output logic [DW-1:0] rd);
      int id = sub_id(t);
      int sl = -1;
      rd = '0;
      if (op[1]) begin
         for (int i = DP - 1; i >= 0; i--) if (!m_vld[id][i]) sl = i;
         if (sl < 0) sl = 0;
         m_vld[id][sl] = 1'b1;
         m_tag[id][sl] = t;
         m_ram[id*DP+sl] = d;
         hit = 1'b1;
      end else begin
         for (int i = DP - 1; i >= 0; i--) if (m_vld[id][i] && m_tag[id][i] == t) sl = i;
         hit = (sl >= 0);
         if (hit && op == 2'b00) rd = m_ram[id*DP+sl];
         if (hit && op == 2'b01) m_ram[id*DP+sl] = d;
      end
   endtask

   task automatic check_outputs();
      logic [NS-1:0] wexp = '0;
      bit vexp = 1'b0;
      int ps = (k - 4) & 7;
      if (k >= 1 && e_vld[(k-1)&7]) wexp[e_id[(k-1)&7]] = 1'b1;
      if (k >= 2 && e_vld[(k-2)&7]) wexp[e_id[(k-2)&7]] = 1'b1;
      chk(wake_o == wexp, "R1/R8 wake vector", int'(wake_o), int'(wexp));
      if (k >= 4) vexp = e_vld[ps];
      chk(res_valid == vexp, "R2 result valid", int'(res_valid), int'(vexp));
      if (vexp) begin
         chk(res_op == e_op[ps], "R2 result op", int'(res_op), int'(e_op[ps]));
         if (e_op[ps][1])
            chk(res_hit == 1'b1 && res_data == '0, "R6 write result",
                int'({res_hit, res_data}), int'({1'b1, 8'h00}));
         else if (!e_hit[ps])
            chk(res_hit == 1'b0 && res_data == '0, "R5 miss result",
                int'({res_hit, res_data}), 0);
         else if (e_op[ps] == 2'b00)
            chk(res_hit == 1'b1 && res_data == e_data[ps], "R3/R7 read hit data",
                int'({res_hit, res_data}), int'({1'b1, e_data[ps]}));
         else
            chk(res_hit == 1'b1 && res_data == '0, "R4 overwrite hit",
                int'({res_hit, res_data}), int'({1'b1, 8'h00}));
      end
   endtask

   task automatic step(input bit v, input logic [1:0] op, input logic [TW-1:0] t,
                       input logic [DW-1:0] d);
      logic h;
      logic [DW-1:0] rd;
      @(negedge clk);
      check_outputs();
      cmd_valid = v;
      cmd_op    = op;
      cmd_tag   = t;
      cmd_data  = d;
      e_vld[k&7] = v;
      if (v) begin
         model(op, t, d, h, rd);
         e_op[k&7]   = op;
         e_hit[k&7]  = h;
         e_data[k&7] = rd;
         e_id[k&7]   = sub_id(t);
      end
      k++;
   endtask

   initial begin
      logic [TW-1:0] same [6];
      int nf;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NS; i++) for (int j = 0; j < DP; j++) m_vld[i][j] = 1'b0;
      for (int i = 0; i < 8; i++) e_vld[i] = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      chk(res_valid == 1'b0 && res_hit == 1'b0, "R10 reset result flags",
          int'({res_valid, res_hit}), 0);
      chk(res_data == '0, "R10 reset data", int'(res_data), 0);
      chk(wake_o == '0, "R10 reset wake", int'(wake_o), 0);
      rst_n = 1'b1;

      // R10/R5: empty store misses; R7 back-to-back visibility
      step(1, 2'b00, 8'h35, 8'h00);
      step(1, 2'b10, 8'h35, 8'hA1);
      step(1, 2'b00, 8'h35, 8'h00);
      step(1, 2'b01, 8'h35, 8'h5C);
      step(1, 2'b00, 8'h35, 8'h00);
      step(1, 2'b01, 8'h77, 8'hEE);
      step(1, 2'b00, 8'h77, 8'h00);
      step(0, 2'b00, 8'h00, 8'h00);
      step(0, 2'b00, 8'h00, 8'h00);

      // R6: fill one subbank past its depth, then read every tag back
      nf = 0;
      for (int t = 1; t < 256 && nf < 6; t++) begin
         if (sub_id(TW'(t)) == sub_id(8'h01) && TW'(t) != 8'h35) begin
            same[nf] = TW'(t);
            nf++;
         end
      end
      for (int i = 0; i < 6; i++) step(1, (i[0] ? 2'b11 : 2'b10), same[i], DW'(8'h10 + i));
      for (int i = 0; i < 6; i++) step(1, 2'b00, same[i], 8'h00);
      for (int i = 0; i < 4; i++) step(0, 2'b00, 8'h00, 8'h00);

      // random traffic over a small tag pool
      for (int n = 0; n < 3000; n++) begin
         int r = $urandom_range(0, 9);
         logic [1:0] op = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : ((r & 1) ? 2'b11 : 2'b10);
         step(($urandom_range(0, 99) < 85), op, TW'($urandom_range(0, 47)),
              DW'($urandom_range(0, 255)));
      end
      for (int i = 0; i < 6; i++) step(0, 2'b00, 8'h00, 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule